// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single transfers on an external data bus for a core that talks to slow peripherals. A transfer starts when the core raises a request while the bus is idle. From the next cycle the block drives the address, the write data for writes, an enable strobe and a read/write line. It then samples an active-low ready input on every rising clock edge. While ready is inactive, the transfer is stretched: the strobes stay asserted and the address and data stay frozen.

The transfer finishes at the first rising edge where ready is found active. At that edge the strobes drop. For a read, the data on the bus is captured and handed to the core with a one-cycle valid pulse. A stall output tells the core that a transfer is still open, so the core holds off until the stall falls. A request made while a transfer is open has no effect. Ready has no effect while the bus is idle.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While reset is asserted, bus_en, bus_wr, stall and rd_valid are 0, and bus_addr, bus_wdata and rd_data are all zero.
- R2: If req is 1 at a rising edge while bus_en is 0, then after that edge bus_en is 1, bus_wr equals req_wr (1 = write, 0 = read), bus_addr equals req_addr, and bus_wdata equals req_wdata for a write or zero for a read.
- R3: If rdy_n is 1 at a rising edge while bus_en is 1, then after that edge bus_en, bus_wr, bus_addr and bus_wdata keep their values.
- R4: If rdy_n is 0 at a rising edge while bus_en is 1, then after that edge bus_en and bus_wr are both 0.
- R5: If rdy_n is already 0 at the first edge after a transfer starts, bus_en stays high for exactly one cycle, with no wait states.
- R6: stall is 1 in exactly the cycles in which bus_en is 1.
- R7: At the edge that completes a read, bus_rdata is stored into rd_data, and rd_valid is 1 for the following cycle only. A completing write leaves rd_valid at 0 and rd_data unchanged.
- R8: A request made while bus_en is 1 is ignored. The transfer in progress keeps its address, data and direction.
- R9: With bus_en at 0 and req at 0, the next cycle still has bus_en at 0, whatever the value of rdy_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; ready is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Core asks for a transfer |
| req_wr | input | 1 | Direction of the requested transfer, 1 = write |
| req_addr | input | AW | Address of the requested transfer |
| req_wdata | input | DW | Data for a requested write |
| rdy_n | input | 1 | Peripheral ready, active low |
| bus_rdata | input | DW | Data returned by the peripheral |
| bus_addr | output | AW | Address driven on the bus |
| bus_wdata | output | DW | Write data driven on the bus |
| bus_en | output | 1 | Transfer enable strobe, active high |
| bus_wr | output | 1 | Read/write line, 1 = write |
| rd_data | output | DW | Read data captured at completion |
| rd_valid | output | 1 | One-cycle pulse marking new rd_data |
| stall | output | 1 | Core must wait while high |

## Verification
A wrong busy state shows up at the ports in the very next cycle. Either bus_en and stall stay high after ready was sampled active, or they fall while ready is still inactive. A wrong capture register shows up as an address or data word that changes during a wait, or as a rd_data value that differs from the bus_rdata value present at the completing edge, visible the cycle after that edge. A direction error shows up as a rd_valid pulse after a write, or as a missing pulse after a read, one cycle after completion.

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rdy_n,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_en,
  output logic          bus_wr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          stall
);

  logic busy;
  wire  accept = req & ~busy;
  wire  finish = busy & ~rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      bus_wr    <= req_wr;
      bus_addr  <= req_addr;
      bus_wdata <= req_wr ? req_wdata : '0;
    end else if (finish) begin
      busy      <= 1'b0;
      bus_wr    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= finish & ~bus_wr;
      if (finish && !bus_wr) rd_data <= bus_rdata;
    end
  end

  assign bus_en = busy;
  assign stall  = busy;

endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
module xbus_wait_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          req_wr,
  input logic [AW-1:0] req_addr,
  input logic          rdy_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_en,
  input logic          bus_wr,
  input logic          rd_valid,
  input logic          stall
);

  always @(posedge clk)
    if (!rst_n)
      AST_RESET_IDLE: assert (!bus_en && !bus_wr && !stall && !rd_valid); // R1

  AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && req) |=> (bus_en && bus_addr == $past(req_addr) && bus_wr == $past(req_wr))); // R2

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && rdy_n) |=> (bus_en && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr))); // R3

  AST_DONE_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !rdy_n) |=> (!bus_en && !bus_wr)); // R4

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(bus_en) && !$past(bus_wr) && !$past(rdy_n))); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && !req) |=> !bus_en); // R9

endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
  .rdy_n(rdy_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_en(bus_en),
  .bus_wr(bus_wr), .rd_valid(rd_valid), .stall(stall)
);

// File: tb/test_xbus_wait_ctrl.sv
module test_xbus_wait_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, req_wr, rdy_n;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, rd_data;
  logic          bus_en, bus_wr, rd_valid, stall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic          m_busy, m_wr, m_rdv;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  xbus_wait_ctrl #(.AW(AW), .DW(DW)) i_xbus_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdy_n(rdy_n), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_en(bus_en), .bus_wr(bus_wr),
    .rd_data(rd_data), .rd_valid(rd_valid), .stall(stall)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_wdata(input logic wr, input logic [DW-1:0] d);
    return wr ? d : '0;
  endfunction

  task automatic model_edge();
    if (!m_busy) begin
      m_rdv = 1'b0;
      if (req) begin
        m_busy  = 1'b1;
        m_wr    = req_wr;
        m_addr  = req_addr;
        m_wdata = exp_wdata(req_wr, req_wdata);
      end
    end else if (!rdy_n) begin
      m_rdv = !m_wr;
      if (!m_wr) m_rdata = bus_rdata;
      m_busy = 1'b0;
      m_wr   = 1'b0;
    end else begin
      m_rdv = 1'b0;
    end
  endtask

  task automatic compare();
    check("R6 stall", stall, m_busy);
    check("R2/R3/R4 bus_en", bus_en, m_busy);
    check("R2/R4 bus_wr", bus_wr, m_wr);
    check("R7 rd_valid", rd_valid, m_rdv);
    check("R7 rd_data", rd_data, m_rdata);
    if (m_busy) begin
      check("R2/R3/R8 bus_addr", bus_addr, m_addr);
      check("R2/R3/R8 bus_wdata", bus_wdata, m_wdata);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic drive(input logic r, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic rn);
    req = r; req_wr = w; req_addr = a; req_wdata = d; rdy_n = rn;
    bus_rdata = DW'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 16'h1234, 16'h5678, 1'b0);
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 bus_en", bus_en, 1'b0);
    check("R1 stall", stall, 1'b0);
    check("R1 rd_valid", rd_valid, 1'b0);
    check("R1 bus_wr", bus_wr, 1'b0);
    check("R1 buses", {bus_addr, bus_wdata}, 32'h0);
    check("R1 rd_data", rd_data, 16'h0);
    m_busy = 0; m_wr = 0; m_rdv = 0; m_addr = 0; m_wdata = 0; m_rdata = 0;
    drive(1'b0, 1'b0, '0, '0, 1'b1);
    rst_n = 1'b1;

    // R9: ready active while idle, no request
    drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
    repeat (3) step();
    check("R9 idle bus_en", bus_en, 1'b0);

    // R5: zero-wait read, ready already active
    drive(1'b1, 1'b0, 16'hA5A5, 16'hFFFF, 1'b0);
    step();
    check("R5 strobe up", bus_en, 1'b1);
    check("R2 read wdata zero", bus_wdata, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
    bus_rdata = 16'hC3C3;
    step();
    check("R5 strobe one cycle", bus_en, 1'b0);
    check("R7 zero-wait read data", rd_data, 16'hC3C3);
    check("R7 zero-wait pulse", rd_valid, 1'b1);
    step();
    check("R7 pulse one cycle", rd_valid, 1'b0);

    // R3/R8: long-wait write with competing requests
    drive(1'b1, 1'b1, 16'h0F0F, 16'hBEEF, 1'b1);
    step();
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, 1'b0, AW'($urandom), DW'($urandom), 1'b1);
      step();
      check("R3 held addr", bus_addr, 16'h0F0F);
      check("R8 held data", bus_wdata, 16'hBEEF);
      check("R3 held wr", bus_wr, 1'b1);
    end
    drive(1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
    step();
    check("R4 write done", bus_en, 1'b0);
    check("R7 write no pulse", rd_valid, 1'b0);
    check("R7 rd_data kept", rd_data, 16'hC3C3);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 2) == 0, $urandom % 2, AW'($urandom), DW'($urandom),
            ($urandom % 3) != 0);
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule